// File: doc/BRIEF.md
# Banked Nibble-Wide Real-Time Clock

This block is a calendar clock that a host reaches through sixteen 4-bit registers on a plain synchronous bus. The host gives an address, write data and a one-cycle write strobe, and it reads the addressed register back combinationally. Addresses 0x0 to 0xc change meaning with a bank field in the control register at 0xd. Bank 0 shows the running time and date as single BCD digits. Bank 1 holds the alarm digits, the 12/24-hour select and a leap-year counter. Banks 2 and 3 are two independent 13-nibble scratch RAMs. Addresses 0xd (control), 0xe (test scratch) and 0xf (divider and alarm clear, pulse enables) are present in every bank.

The clock runs from a 16 Hz tick input. A prescaler of `DIV_BITS` bits turns this tick into one-second events. Each second carries through seconds, minutes, hours, day of month, day of week, month and two-digit year, and month lengths follow the leap-year counter. The host can stop the count by clearing a run bit, so that it can read or set the time as a consistent set. A second that falls due while the count is stopped is kept and applied as soon as the count runs again.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the control register reads 0x8 (running, bank 0), the time digits read 00:00:00 with day 01, month 01, year 00 and weekday 0, and the 12/24 select (bank 1, address 0xa, bit 0) reads 1.
- R2: Every 2^DIV_BITS rising-tick cycles give one second. Bank 0 holds, at addresses 0x0 to 0xc, seconds ones/tens, minutes ones/tens, hours ones/tens, weekday, day ones/tens, month ones/tens and year ones/tens. Seconds and minutes wrap from 59 to 00 and carry onward.
- R3: In 24-hour mode (select = 1) hours wrap from 23 to 00 and carry into the day. The weekday counts 0 to 6, wraps to 0, and advances with the day.
- R4: In 12-hour mode (select = 0) the hour tens digit uses bit 0 for the tens and bit 1 for PM. 11 goes to 12 and toggles PM, 12 goes to 01, and the step from 11 PM to 12 AM advances the day.
- R5: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the leap counter (bank 1, address 0xb) is 0 and 28 days otherwise. The other months have 31. Month 12 wraps to 1 and carries into the year. The year wraps from 99 to 00. Each year carry steps the leap counter modulo 4.
- R6: While control bit 3 (run) is 0 the time digits do not advance. One second that falls due in that time is applied once, in the cycle after run is set again.
- R7: Control bits 1:0 select the bank behind addresses 0x0 to 0xc. A write reaches only the selected bank, and the RAM banks keep their contents across bank changes.
- R8: The control, test and reset registers at 0xd, 0xe and 0xf read and write the same in every bank.
- R9: Writing 1 to bit 1 of register 0xf clears the prescaler and any held second, so the next second falls 2^DIV_BITS ticks after the write.
- R10: Writing 1 to bit 0 of register 0xf clears bank 1 addresses 0x0 to 0x9 (the alarm digits) and leaves the 12/24 select, the leap counter and the time unchanged.
- R11: Bit 2 of register 0xf gates the 16 Hz tick onto `pulse_fast_o`. Bit 3 gates the prescaler MSB, a 1 Hz square wave, onto `pulse_sec_o`. These two bits read back at the same positions of 0xf.
- R12: `alarm_o` is high when control bit 2 (alarm enable) is set and bank 1 addresses 0x2 to 0x8 equal bank 0 addresses 0x2 to 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle 16 Hz tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data of the addressed register |
| pulse_fast_o | output | 1 | Gated 16 Hz tick |
| pulse_sec_o | output | 1 | Gated 1 Hz square wave |
| alarm_o | output | 1 | Alarm match |

## Verification
The hardest state to reach is a held second: the count must be stopped across a full prescaler period, and the bench has to confirm that more than one missed second still yields exactly one step. The stimulus clears the run bit and sends two full prescaler periods of ticks. It reads the seconds digit while the count is stopped, sets run again, and reads the digit one cycle later and again several cycles after that. Calendar corners such as the leap day, the 12-hour noon and midnight steps and the century wrap are reached by writing each digit to one second before the boundary, so that no long run of ticks is needed.

// File: rtl/rtc_pkg.sv
// Shared constants, bank encoding and BCD helpers for the banked clock.
// Assumes 4-bit registers and a 4-bit address space.
package rtc_pkg;
    localparam int NIB  = 4;
    localparam int AW   = 4;
    localparam int NREG = 13;
    localparam int NALM = 10;

    localparam logic [AW-1:0] A_LAST_LO = 4'hC;
    localparam logic [AW-1:0] A_SEL24   = 4'hA;
    localparam logic [AW-1:0] A_LEAP    = 4'hB;
    localparam logic [AW-1:0] A_CTRL    = 4'hD;
    localparam logic [AW-1:0] A_TEST    = 4'hE;
    localparam logic [AW-1:0] A_CLR     = 4'hF;

    typedef enum logic [1:0] {BK_TIME, BK_ALRM, BK_RAMA, BK_RAMB} bank_e;

    // Two BCD digits to a binary value.
    function automatic logic [7:0] bcd_val(input logic [3:0] t, input logic [3:0] o);
        return {4'b0, t} * 8'd10 + {4'b0, o};
    endfunction

    // Tens digit of a binary value below 100.
    function automatic logic [3:0] tens_of(input logic [7:0] v);
        logic [7:0] q;
        q = v / 8'd10;
        return q[3:0];
    endfunction

    // Ones digit of a binary value.
    function automatic logic [3:0] ones_of(input logic [7:0] v);
        logic [7:0] r;
        r = v % 8'd10;
        return r[3:0];
    endfunction

    // Days in a month; leap selects the 29-day February.
    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
        case (mon)
            8'd2:                      return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_nibble_ram.sv
// Nibble-wide register file with an optional bulk clear of its low entries.
// Assumes the address is checked here; writes past DEPTH are dropped.
module rtc_nibble_ram #(
    parameter int DEPTH     = 13,
    parameter int CLR_DEPTH = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [rtc_pkg::AW-1:0]       addr,
    input  logic [rtc_pkg::NIB-1:0]      wdata,
    input  logic                         clr,
    output logic [DEPTH-1:0][rtc_pkg::NIB-1:0] img_o
);
    logic [rtc_pkg::NIB-1:0] mem [DEPTH];

    // Storage update: reset, bulk clear, then single-entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < CLR_DEPTH; i++) mem[i] <= '0;
        end else if (we && int'(addr) < DEPTH) begin
            mem[addr] <= wdata;
        end
    end

    // Whole-array image for readers.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) img_o[i] = mem[i];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!we && !clr) |=> mem[g] == $past(mem[g]));  // R7
        if (g < CLR_DEPTH) begin : g_clr
            AST_ALARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> mem[g] == '0);  // R10
        end
    end
endmodule

// File: rtl/rtc_time_core.sv
// Time and date digit counters with carry chain, 12/24 select and leap counter.
// Assumes adv is a one-cycle second event; host writes win over advance per digit.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [NIB-1:0]             wdata,
    input  logic                       sel_we,
    input  logic                       leap_we,
    output logic [NREG-1:0][NIB-1:0]   dig_o,
    output logic                       sel24_o,
    output logic [1:0]                 leap_o
);
    logic [NREG-1:0][NIB-1:0] dig, nxt;
    logic       sel24;
    logic [1:0] leap;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    // Next digits for one second, computed through the full carry chain.
    always_comb begin
        logic [7:0] v, hr, dy, mo;
        logic       pm;
        nxt = dig;
        c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
        hr = '0; dy = '0; mo = '0; pm = 1'b0;
        v = bcd_val(dig[1], dig[0]);
        c_min = v >= 8'd59;
        v = c_min ? 8'd0 : v + 8'd1;
        nxt[1] = tens_of(v); nxt[0] = ones_of(v);
        if (c_min) begin
            v = bcd_val(dig[3], dig[2]);
            c_hr = v >= 8'd59;
            v = c_hr ? 8'd0 : v + 8'd1;
            nxt[3] = tens_of(v); nxt[2] = ones_of(v);
        end
        if (c_hr) begin
            if (sel24) begin
                hr = bcd_val({2'b0, dig[5][1:0]}, dig[4]);
                c_day = hr >= 8'd23;
                v = c_day ? 8'd0 : hr + 8'd1;
                nxt[5] = tens_of(v); nxt[4] = ones_of(v);
            end else begin
                hr = bcd_val({3'b0, dig[5][0]}, dig[4]);
                pm = dig[5][1];
                if (hr == 8'd11) begin
                    v = 8'd12; c_day = pm; pm = ~pm;
                end else if (hr >= 8'd12) begin
                    v = 8'd1;
                end else begin
                    v = hr + 8'd1;
                end
                nxt[5] = {2'b0, pm, v >= 8'd10};
                nxt[4] = ones_of(v);
            end
        end
        if (c_day) begin
            nxt[6] = (dig[6] >= 4'd6) ? 4'd0 : dig[6] + 4'd1;
            mo = bcd_val(dig[10], dig[9]);
            dy = bcd_val(dig[8], dig[7]);
            c_mon = dy >= month_len(mo, leap == 2'd0);
            v = c_mon ? 8'd1 : dy + 8'd1;
            nxt[8] = tens_of(v); nxt[7] = ones_of(v);
        end
        if (c_mon) begin
            c_yr = mo >= 8'd12;
            v = c_yr ? 8'd1 : mo + 8'd1;
            nxt[10] = tens_of(v); nxt[9] = ones_of(v);
        end
        if (c_yr) begin
            v = bcd_val(dig[12], dig[11]);
            v = (v >= 8'd99) ? 8'd0 : v + 8'd1;
            nxt[12] = tens_of(v); nxt[11] = ones_of(v);
        end
    end

    // Digit state: reset value, second advance, then host digit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig    <= '0;
            dig[7] <= 4'd1;
            dig[9] <= 4'd1;
        end else begin
            if (adv) dig <= nxt;
            if (wr_en && wr_addr <= A_LAST_LO) dig[wr_addr] <= wdata;
        end
    end

    // Mode select and leap counter: host write wins over year carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel24 <= 1'b1;
            leap  <= '0;
        end else begin
            if (sel_we) sel24 <= wdata[0];
            if (leap_we)          leap <= wdata[1:0];
            else if (adv && c_yr) leap <= leap + 2'd1;
        end
    end

    assign dig_o   = dig;
    assign sel24_o = sel24;
    assign leap_o  = leap;

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_en) |=> dig == $past(dig));  // R6
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && dig[1] == 4'd5 && dig[0] == 4'd9) |=> (dig[1] == 4'd0 && dig[0] == 4'd0));  // R2
    AST_HOUR24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_en && !sel_we && sel24 && dig[5] == 4'd2 && dig[4] == 4'd3 &&
         dig[3] == 4'd5 && dig[2] == 4'd9 && dig[1] == 4'd5 && dig[0] == 4'd9)
        |=> (dig[5] == 4'd0 && dig[4] == 4'd0));  // R3
endmodule

// File: rtl/nibble_rtc.sv
// Top of the banked clock: control, test and clear registers, prescaler,
// held-second logic, bank decode, read mux, pulse outputs and alarm match.
// Assumes tick_in is a one-cycle pulse at 16 Hz and a single-cycle write strobe.
module nibble_rtc
    import rtc_pkg::*;
#(
    parameter int DIV_BITS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_in,
    input  logic           bus_wr,
    input  logic [3:0]     bus_addr,
    input  logic [3:0]     bus_wdata,
    output logic [3:0]     bus_rdata,
    output logic           pulse_fast_o,
    output logic           pulse_sec_o,
    output logic           alarm_o
);
    localparam int NRAM = 2;

    logic [NIB-1:0]          ctrl, test_q;
    logic [1:0]              pul_en;
    logic [DIV_BITS-1:0]     div;
    logic                    held;
    bank_e                   bank;
    logic                    run, alm_en, lo, sec_evt, adv;
    logic                    clr_wr, div_clr, alm_clr;
    logic [NREG-1:0][NIB-1:0] dig;
    logic [NALM-1:0][NIB-1:0] alm_img;
    logic [NREG-1:0][NIB-1:0] ram_img [NRAM];
    logic                    sel24;
    logic [1:0]              leap;

    assign bank    = bank_e'(ctrl[1:0]);
    assign run     = ctrl[3];
    assign alm_en  = ctrl[2];
    assign lo      = bus_addr <= A_LAST_LO;
    assign clr_wr  = bus_wr && bus_addr == A_CLR;
    assign div_clr = clr_wr && bus_wdata[1];
    assign alm_clr = clr_wr && bus_wdata[0];
    assign sec_evt = tick_in && (&div);
    assign adv     = run && (sec_evt || held);

    // Control, test scratch and pulse-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= 4'h8;
            test_q <= '0;
            pul_en <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) ctrl   <= bus_wdata;
            if (bus_addr == A_TEST) test_q <= bus_wdata;
            if (clr_wr)             pul_en <= bus_wdata[3:2];
        end
    end

    // Prescaler from the 16 Hz tick to seconds.
    always_ff @(posedge clk) begin
        if (!rst_n || div_clr) div <= '0;
        else if (tick_in)      div <= div + 1'b1;
    end

    // Held second: set while stopped, consumed when running.
    always_ff @(posedge clk) begin
        if (!rst_n || div_clr) held <= 1'b0;
        else if (run)          held <= sec_evt && held;
        else                   held <= held || sec_evt;
    end

    rtc_time_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .wr_en   (bus_wr && lo && bank == BK_TIME),
        .wr_addr (bus_addr),
        .wdata   (bus_wdata),
        .sel_we  (bus_wr && bank == BK_ALRM && bus_addr == A_SEL24),
        .leap_we (bus_wr && bank == BK_ALRM && bus_addr == A_LEAP),
        .dig_o   (dig),
        .sel24_o (sel24),
        .leap_o  (leap)
    );

    rtc_nibble_ram #(.DEPTH(NALM), .CLR_DEPTH(NALM)) u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && bank == BK_ALRM && int'(bus_addr) < NALM),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .clr   (alm_clr),
        .img_o (alm_img)
    );

    for (genvar g = 0; g < NRAM; g++) begin : g_ram
        rtc_nibble_ram #(.DEPTH(NREG), .CLR_DEPTH(0)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr && lo && ctrl[1:0] == 2'(g + 2)),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .clr   (1'b0),
            .img_o (ram_img[g])
        );
    end

    // Read mux: shared registers first, then the selected bank.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)      bus_rdata = ctrl;
        else if (bus_addr == A_TEST) bus_rdata = test_q;
        else if (bus_addr == A_CLR)  bus_rdata = {pul_en, 2'b00};
        else begin
            case (bank)
                BK_TIME: bus_rdata = dig[bus_addr];
                BK_ALRM: begin
                    if (int'(bus_addr) < NALM)    bus_rdata = alm_img[bus_addr];
                    else if (bus_addr == A_SEL24) bus_rdata = {3'b0, sel24};
                    else if (bus_addr == A_LEAP)  bus_rdata = {2'b0, leap};
                end
                BK_RAMA: bus_rdata = ram_img[0][bus_addr];
                default: bus_rdata = ram_img[1][bus_addr];
            endcase
        end
    end

    // Pulse outputs and alarm comparison over minutes to day digits.
    assign pulse_fast_o = pul_en[0] && tick_in;
    assign pulse_sec_o  = pul_en[1] && div[DIV_BITS-1];
    assign alarm_o      = alm_en && (alm_img[8:2] == dig[8:2]);

    AST_HELD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && sec_evt && !div_clr) |=> held);  // R6
    AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        div_clr |=> (div == '0 && !held));  // R9
endmodule

// File: tb/nibble_rtc_bench.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares them.
module nibble_rtc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       pulse_fast_o, pulse_sec_o, alarm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;
        logic [3:0] exp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    nibble_rtc u_nibble_rtc (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pulse_fast_o(pulse_fast_o), .pulse_sec_o(pulse_sec_o), .alarm_o(alarm_o)
    );

    // Monitor: mid low phase, pop and compare every queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                exp_t it;
                logic [3:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {3'b0, pulse_fast_o};
                    2: act = {3'b0, pulse_sec_o};
                    default: act = {3'b0, alarm_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb.push_back('{0, e, tag});
    endtask

    task automatic out_chk(input int kind, input logic e, input string tag);
        @(negedge clk);
        sb.push_back('{kind, {3'b0, e}, tag});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_time(input logic [3:0] h10, h1, m10, m1, s10, s1);
        wr(4'h5, h10); wr(4'h4, h1); wr(4'h3, m10);
        wr(4'h2, m1);  wr(4'h1, s10); wr(4'h0, s1);
    endtask

    task automatic set_date(input logic [3:0] d10, d1, mo10, mo1, y10, y1);
        wr(4'h8, d10); wr(4'h7, d1); wr(4'hA, mo10);
        wr(4'h9, mo1); wr(4'hC, y10); wr(4'hB, y1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'hD, 4'h8, "R1 ctrl");
        rd(4'h0, 4'h0, "R1 sec1");   rd(4'h5, 4'h0, "R1 hr10");
        rd(4'h6, 4'h0, "R1 wday");   rd(4'h7, 4'h1, "R1 day1");
        rd(4'h9, 4'h1, "R1 mon1");   rd(4'hC, 4'h0, "R1 yr10");
        wr(4'hD, 4'h9); rd(4'hA, 4'h1, "R1 sel24"); wr(4'hD, 4'h8);

        // R2 seconds and minutes carry into hours
        set_time(4'd1, 4'd3, 4'd5, 4'd9, 4'd5, 4'd8);
        ticks(16); rd(4'h0, 4'd9, "R2 sec1 step");
        ticks(16);
        rd(4'h0, 4'd0, "R2 sec1 wrap"); rd(4'h1, 4'd0, "R2 sec10 wrap");
        rd(4'h3, 4'd0, "R2 min10 wrap"); rd(4'h4, 4'd4, "R2 hr1 carry");
        rd(4'h5, 4'd1, "R2 hr10 keep");

        // R3 24-hour wrap and weekday wrap
        set_date(4'd1, 4'd5, 4'd0, 4'd3, 4'd2, 4'd4);
        wr(4'h6, 4'd6);
        set_time(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h5, 4'd0, "R3 hr10"); rd(4'h4, 4'd0, "R3 hr1");
        rd(4'h6, 4'd0, "R3 wday wrap"); rd(4'h7, 4'd6, "R3 day1");

        // R5 month lengths, leap day, year wrap
        set_date(4'd3, 4'd0, 4'd0, 4'd4, 4'd2, 4'd4);
        set_time(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h8, 4'd0, "R5 apr30 d10"); rd(4'h7, 4'd1, "R5 apr30 d1");
        rd(4'h9, 4'd5, "R5 apr30 mon");
        set_date(4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd4);
        set_time(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h8, 4'd2, "R5 leap d10"); rd(4'h7, 4'd9, "R5 leap d1");
        set_time(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h7, 4'd1, "R5 feb29 next"); rd(4'h9, 4'd3, "R5 feb29 mon");
        wr(4'hD, 4'h9); wr(4'hB, 4'd1); wr(4'hD, 4'h8);
        set_date(4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd5);
        set_time(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h7, 4'd1, "R5 feb28 next"); rd(4'h9, 4'd3, "R5 feb28 mon");
        set_date(4'd3, 4'd1, 4'd1, 4'd2, 4'd9, 4'd9);
        set_time(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'hC, 4'd0, "R5 yr10 wrap"); rd(4'hB, 4'd0, "R5 yr1 wrap");
        rd(4'hA, 4'd0, "R5 mon10");     rd(4'h9, 4'd1, "R5 mon1");
        wr(4'hD, 4'h9); rd(4'hB, 4'd2, "R5 leap step"); 

        // R4 12-hour mode
        wr(4'hA, 4'd0); wr(4'hD, 4'h8);
        set_time(4'd1, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h5, 4'd3, "R4 noon pm"); rd(4'h4, 4'd2, "R4 noon hr1");
        set_time(4'd3, 4'd2, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h5, 4'd2, "R4 one pm"); rd(4'h4, 4'd1, "R4 one hr1");
        set_date(4'd0, 4'd5, 4'd0, 4'd1, 4'd0, 4'd1);
        set_time(4'd3, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        ticks(16);
        rd(4'h5, 4'd1, "R4 midnight am"); rd(4'h4, 4'd2, "R4 midnight hr1");
        rd(4'h7, 4'd6, "R4 midnight day");

        // R6 stop, hold one second, resume
        wr(4'hD, 4'h0);
        wr(4'h1, 4'd0); wr(4'h0, 4'd3);
        ticks(16); rd(4'h0, 4'd3, "R6 stopped 1");
        ticks(16); rd(4'h0, 4'd3, "R6 stopped 2");
        wr(4'hD, 4'h8); idle(1);
        rd(4'h0, 4'd4, "R6 held applied");
        idle(3); rd(4'h0, 4'd4, "R6 applied once");

        // R9 prescaler clear
        ticks(5); wr(4'hF, 4'h2);
        ticks(15); rd(4'h0, 4'd4, "R9 no early second");
        ticks(1);  rd(4'h0, 4'd5, "R9 second after clear");

        // R11 pulse outputs
        wr(4'hF, 4'hC); rd(4'hF, 4'hC, "R11 enables read");
        @(negedge clk); tick_in = 1'b1;
        sb.push_back('{1, 4'd1, "R11 fast on"});
        @(negedge clk); tick_in = 1'b0;
        out_chk(2, 1'b0, "R11 sec low half");
        ticks(7); out_chk(2, 1'b1, "R11 sec high half");
        ticks(8); out_chk(2, 1'b0, "R11 sec wraps low");
        wr(4'hF, 4'h0);
        @(negedge clk); tick_in = 1'b1;
        sb.push_back('{1, 4'd0, "R11 fast gated"});
        @(negedge clk); tick_in = 1'b0;
        ticks(15);

        // R7 and R8 banks and shared registers
        wr(4'hD, 4'hA); wr(4'h3, 4'hA);
        wr(4'hD, 4'hB); wr(4'h3, 4'h5); wr(4'hE, 4'h6);
        rd(4'h3, 4'h5, "R7 bank3 data");
        wr(4'hD, 4'hA);
        rd(4'h3, 4'hA, "R7 bank2 kept");
        rd(4'hE, 4'h6, "R8 test other bank");
        rd(4'hD, 4'hA, "R8 ctrl other bank");
        wr(4'hD, 4'h9); rd(4'h3, 4'h0, "R7 alarm bank untouched");

        // R12 and R10 alarm match and alarm clear
        wr(4'hD, 4'h8);
        wr(4'h2, 4'd7); wr(4'h3, 4'd3); wr(4'h4, 4'd5); wr(4'h5, 4'd0);
        wr(4'h6, 4'd2); wr(4'h7, 4'd9); wr(4'h8, 4'd1);
        wr(4'hD, 4'h9);
        wr(4'h2, 4'd7); wr(4'h3, 4'd3); wr(4'h4, 4'd5); wr(4'h5, 4'd0);
        wr(4'h6, 4'd2); wr(4'h7, 4'd9); wr(4'h8, 4'd1); wr(4'hA, 4'd1);
        out_chk(3, 1'b0, "R12 disabled");
        wr(4'hD, 4'hD);
        out_chk(3, 1'b1, "R12 match");
        wr(4'h4, 4'd6);
        out_chk(3, 1'b0, "R12 mismatch");
        wr(4'h4, 4'd5);
        wr(4'hF, 4'h1);
        out_chk(3, 1'b0, "R10 cleared no match");
        rd(4'h5, 4'h0, "R10 alarm digit cleared");
        rd(4'h7, 4'h0, "R10 alarm day cleared");
        rd(4'hA, 4'h1, "R10 sel24 kept");
        wr(4'hD, 4'h8);
        rd(4'h2, 4'd7, "R10 time kept");

        idle(2);
        #6;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule